// File: doc/BRIEF.md
# Low-Voltage Monitor Status Registers

This block is the byte-wide register front end of a supply monitor. Two comparator outputs arrive as synchronous level inputs: a detect input and a warning input. For each input the block keeps a sticky flag, an interrupt enable and a trip-level select field. Each flag can be cleared by writing one to an acknowledge bit. Both flags combine into one interrupt request. The detect flag can also raise a reset request, and the bit that enables this can be written only once after each chip reset. The two registers sit at offsets 0 (detect) and 1 (warning) of a small write port. The read data is a combinational view of the register selected by the address.

There are two reset domains. The power-on reset clears everything. The chip reset clears everything except the two level-select fields. A low-power-mode input stops either flag from being set while it is high.

Three small state machines do the control work. Each flag channel has its own machine. Its states are FLG_IDLE (flag clear) and FLG_SET (flag set). The transition *arm* moves FLG_IDLE to FLG_SET on a set condition. The transition *ack* moves FLG_SET to FLG_IDLE on an acknowledge when no set condition is present. The reset-enable lock machine has the states LK_OPEN and LK_SHUT. Its transition *seal* is taken on the first write to offset 0 after chip reset. LK_SHUT is left only through chip reset.

Top module: `lvmon_regs`

## Requirements
- R1: After power-on reset (both resets low), offset 0 reads 0x10 and offset 1 reads 0x00. A chip reset alone returns offset 0 to 0x10 and offset 1 to 0x00, except that both level fields in bits [1:0] keep their values.
- R2: The detect register layout is [1:0] level, [4] reset enable, [5] interrupt enable, [6] acknowledge, [7] flag. The warning register layout is [1:0] level, [5] interrupt enable, [6] acknowledge, [7] flag. Acknowledge bits and all unused bits read 0.
- R3: A write with bit 6 set clears that register's flag in the cycle after the write.
- R4: A flag is set by a 0-to-1 change of its comparator input. A flag is also set in the first cycle after chip reset if that input is already 1. A comparator held at 1 does not set the flag again after an acknowledge.
- R5: When a set condition and an acknowledge occur in the same cycle, the flag ends at 1.
- R6: Writes never set a flag. A write of 1 to bit 7 has no effect on it.
- R7: The first write to offset 0 after chip reset loads bit 4 (reset enable, reset value 1). Every later write to offset 0 leaves bit 4 unchanged until the next chip reset.
- R8: The reset request output is 1 exactly when reset enable is 1 and the detect flag is 1.
- R9: The interrupt request output is 1 when at least one flag is 1 and that flag's interrupt enable is 1.
- R10: While the low-power input is 1, neither flag can be set, whatever the comparator inputs and enables.
- R11: The detect level codes 2 and 3 are reserved. A write carrying one of them leaves the detect level unchanged. The warning level accepts all four codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all fields |
| rst_n | input | 1 | Chip reset, active low, asynchronous; clears all fields but the level selects |
| lowpwr_i | input | 1 | Low-power mode; blocks flag setting while high |
| det_cmp_i | input | 1 | Synchronous detect comparator level (1 = supply below the detect trip point) |
| warn_cmp_i | input | 1 | Synchronous warning comparator level (1 = supply below the warning trip point) |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| addr_i | input | 1 | Register offset: 0 detect, 1 warning |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read view of the register at addr_i |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
The assertions assume that the comparator inputs and the low-power input are already synchronous to clk and change only between clock edges. They also assume that the write strobe, address and data are stable around each rising edge, and that chip reset is asserted whenever power-on reset is. The bench drives all of these on the falling edge and holds them through the next rising edge. It releases the resets on a falling edge, and it always pulls chip reset low together with power-on reset. The stimulus covers both ways a flag is set: a 0-to-1 input change and a level already present at reset release. It also covers an acknowledge that coincides with a new set condition, and the second write to the one-shot reset-enable bit.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
    localparam int REG_W   = 8;
    localparam int LVL_W   = 2;
    localparam int NUM_CH  = 2;
    localparam int ADDR_W  = $clog2(NUM_CH);
    localparam int DET_CH  = 0;
    localparam int WARN_CH = 1;

    localparam int RE_BIT   = 4;
    localparam int IE_BIT   = 5;
    localparam int ACK_BIT  = 6;
    localparam int FLAG_BIT = 7;

    localparam logic [LVL_W-1:0] DET_LVL_MAX = LVL_W'(1);

    typedef enum logic {FLG_IDLE = 1'b0, FLG_SET = 1'b1} flag_state_t;
    typedef enum logic {LK_OPEN = 1'b0, LK_SHUT = 1'b1} lock_state_t;
endpackage

// File: rtl/lvmon_flag.sv
module lvmon_flag import lvmon_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    input  logic lowpwr_i,
    input  logic ack_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;
    logic        cmp_prev_q;
    logic        set_now;

    // previous comparator level; cleared by reset so an input already high sets the flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_prev_q <= 1'b0;
        else        cmp_prev_q <= cmp_i;
    end

    assign set_now = cmp_i && !cmp_prev_q && !lowpwr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_now)            state_d = FLG_SET;   // arm
            FLG_SET:  if (ack_i && !set_now)  state_d = FLG_IDLE;  // ack
            default:                          state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FLG_SET);
    end

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_now) |=> !flag_o);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_now |=> flag_o);
    p_no_spurious_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(cmp_i && !cmp_prev_q)) |=> !flag_o);
    p_lowpwr_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/lvmon_lock.sv
module lvmon_lock import lvmon_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic bit_i,
    output logic en_o
);
    lock_state_t state_q, state_d;
    logic        en_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (wr_i) state_d = LK_SHUT;  // seal
            LK_SHUT:           state_d = LK_SHUT;
            default:           state_d = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             en_q <= 1'b1;
        else if (state_q == LK_OPEN && wr_i)    en_q <= bit_i;
    end

    always_comb begin
        en_o = en_q;
    end

    p_lock_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SHUT) |=> $stable(en_o));
endmodule

// File: rtl/lvmon_regs.sv
module lvmon_regs import lvmon_pkg::*; (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              lowpwr_i,
    input  logic              det_cmp_i,
    input  logic              warn_cmp_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic                  chip_rst_n;
    logic [NUM_CH-1:0]     cmp_v;
    logic [NUM_CH-1:0]     wr_hit;
    logic [NUM_CH-1:0]     ack_v;
    logic [NUM_CH-1:0]     flag_v;
    logic [NUM_CH-1:0]     ie_q;
    logic [LVL_W-1:0]      lvl_q [NUM_CH];
    logic [REG_W-1:0]      word_v [NUM_CH];
    logic                  re_en;

    assign chip_rst_n = rst_n & por_n;
    assign cmp_v[DET_CH]  = det_cmp_i;
    assign cmp_v[WARN_CH] = warn_cmp_i;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign wr_hit[i] = wr_en_i && (addr_i == ADDR_W'(i));
        assign ack_v[i]  = wr_hit[i] && wdata_i[ACK_BIT];

        lvmon_flag u_flag (
            .clk      (clk),
            .rst_n    (chip_rst_n),
            .cmp_i    (cmp_v[i]),
            .lowpwr_i (lowpwr_i),
            .ack_i    (ack_v[i]),
            .flag_o   (flag_v[i])
        );

        always_ff @(posedge clk or negedge chip_rst_n) begin
            if (!chip_rst_n)    ie_q[i] <= 1'b0;
            else if (wr_hit[i]) ie_q[i] <= wdata_i[IE_BIT];
        end

        // level select lives in the power-on domain; writes only while chip reset is released
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                lvl_q[i] <= '0;
            end else if (wr_hit[i] && rst_n) begin
                if (i != DET_CH || wdata_i[LVL_W-1:0] <= DET_LVL_MAX)
                    lvl_q[i] <= wdata_i[LVL_W-1:0];
            end
        end

        always_comb begin
            word_v[i]              = '0;
            word_v[i][LVL_W-1:0]   = lvl_q[i];
            word_v[i][IE_BIT]      = ie_q[i];
            word_v[i][FLAG_BIT]    = flag_v[i];
            if (i == DET_CH) word_v[i][RE_BIT] = re_en;
        end

        p_level_por_only_r1: assert property (@(posedge clk) disable iff (!por_n)
            !rst_n |=> $stable(lvl_q[i]));
    end

    lvmon_lock u_lock (
        .clk   (clk),
        .rst_n (chip_rst_n),
        .wr_i  (wr_hit[DET_CH]),
        .bit_i (wdata_i[RE_BIT]),
        .en_o  (re_en)
    );

    always_comb begin
        rdata_o   = word_v[addr_i];
        irq_o     = |(flag_v & ie_q);
        rst_req_o = re_en && flag_v[DET_CH];
    end

    p_det_level_legal_r11: assert property (@(posedge clk) disable iff (!por_n)
        lvl_q[DET_CH] <= DET_LVL_MAX);
    p_ack_reads_zero_r2: assert property (@(posedge clk) disable iff (!chip_rst_n)
        !rdata_o[ACK_BIT]);
endmodule

// File: tb/tb_lvmon_regs.sv
module tb_lvmon_regs;
    logic       clk = 1'b0;
    logic       por_n, rst_n, lowpwr_i, det_cmp_i, warn_cmp_i, wr_en_i;
    logic [0:0] addr_i;
    logic [7:0] wdata_i, rdata_o;
    logic       irq_o, rst_req_o;
    int         total = 0, bad = 0, cycles = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    lvmon_regs dut (.*);

    // {wr, addr, wdata, det, warn, lowpwr, exp_r0, exp_r1, exp_irq, exp_rst}
    localparam int NV = 16;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0, 8'h10,8'h00, 1'b0,1'b0},
        {1'b1,1'b1,8'h23, 1'b0,1'b0,1'b0, 8'h10,8'h23, 1'b0,1'b0},
        {1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0, 8'h10,8'hA3, 1'b1,1'b0},
        {1'b1,1'b1,8'h63, 1'b0,1'b1,1'b0, 8'h10,8'h23, 1'b0,1'b0},
        {1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0, 8'h10,8'h23, 1'b0,1'b0},
        {1'b1,1'b1,8'h63, 1'b0,1'b1,1'b0, 8'h10,8'hA3, 1'b1,1'b0},
        {1'b1,1'b1,8'h43, 1'b0,1'b1,1'b0, 8'h10,8'h03, 1'b0,1'b0},
        {1'b1,1'b1,8'h81, 1'b0,1'b0,1'b0, 8'h10,8'h01, 1'b0,1'b0},
        {1'b1,1'b0,8'h21, 1'b0,1'b0,1'b0, 8'h21,8'h01, 1'b0,1'b0},
        {1'b1,1'b0,8'h31, 1'b0,1'b0,1'b0, 8'h21,8'h01, 1'b0,1'b0},
        {1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0, 8'hA1,8'h01, 1'b1,1'b0},
        {1'b1,1'b0,8'h61, 1'b1,1'b0,1'b0, 8'h21,8'h01, 1'b0,1'b0},
        {1'b1,1'b0,8'h22, 1'b0,1'b0,1'b0, 8'h21,8'h01, 1'b0,1'b0},
        {1'b0,1'b0,8'h00, 1'b1,1'b1,1'b1, 8'h21,8'h01, 1'b0,1'b0},
        {1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1, 8'h21,8'h01, 1'b0,1'b0},
        {1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0, 8'hA1,8'h01, 1'b1,1'b0}
    };
    string vtag [NV];

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic read_check(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                              input logic eirq, input logic erst);
        addr_i = 1'b0; #1;
        check(tag, "offset0", rdata_o, e0);
        addr_i = 1'b1; #1;
        check(tag, "offset1", rdata_o, e1);
        check(tag, "irq", {7'd0, irq_o}, {7'd0, eirq});
        check(tag, "rst_req", {7'd0, rst_req_o}, {7'd0, erst});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++; bad++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        vtag = '{"R1_R2", "R2", "R4_R9", "R3_R4", "R4", "R5", "R3_R9", "R6",
                 "R7_R11", "R7", "R4_R9", "R3_R4", "R11", "R10", "R10", "R4_R9"};
        por_n = 0; rst_n = 0; lowpwr_i = 0; det_cmp_i = 0; warn_cmp_i = 0;
        wr_en_i = 0; addr_i = 0; wdata_i = 0;
        repeat (3) @(negedge clk);
        read_check("R1", 8'h10, 8'h00, 1'b0, 1'b0);
        por_n = 1; rst_n = 1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en_i    = VEC[v][30];
            addr_i     = VEC[v][29];
            wdata_i    = VEC[v][28:21];
            det_cmp_i  = VEC[v][20];
            warn_cmp_i = VEC[v][19];
            lowpwr_i   = VEC[v][18];
            @(posedge clk); #2;
            wr_en_i = 0;
            read_check(vtag[v], VEC[v][17:10], VEC[v][9:2], VEC[v][1], VEC[v][0]);
        end

        // R1: chip reset keeps both levels, detect input already high
        @(negedge clk);
        rst_n = 0; det_cmp_i = 1; #1;
        read_check("R1", 8'h11, 8'h01, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #2;
        // R4 level-after-reset, R8 reset request with default enable
        read_check("R8", 8'h91, 8'h01, 1'b0, 1'b1);

        // R7 first write after reset clears the enable, then R3 ack
        @(negedge clk);
        wr_en_i = 1; addr_i = 0; wdata_i = 8'h41;
        @(posedge clk); #2; wr_en_i = 0;
        read_check("R7", 8'h01, 8'h01, 1'b0, 1'b0);
        @(negedge clk);
        wr_en_i = 1; addr_i = 0; wdata_i = 8'h11;
        @(posedge clk); #2; wr_en_i = 0;
        read_check("R7", 8'h01, 8'h01, 1'b0, 1'b0);

        // R1 power-on reset clears everything
        @(negedge clk);
        por_n = 0; rst_n = 0; det_cmp_i = 0; #1;
        read_check("R1", 8'h10, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        por_n = 1; rst_n = 1;
        @(posedge clk); #2;
        read_check("R1", 8'h10, 8'h00, 1'b0, 1'b0);

        finish_run();
    end
endmodule